// File: doc/BRIEF.md
# Associative Page Translator with Lockout

This block turns a central-store address into a physical memory address. Memory is divided into 512-word blocks and is held in a fixed set of page frames. Each frame has a page register that holds the number of the block now resident, a lockout bit and a use bit. The block number of every demanded address is compared against all page registers in the same cycle. On a single match, the 5-bit index of the matching frame replaces the block-number field, and the 9-bit word offset passes through unchanged.

Whether an access is allowed depends on the lockout bit and on who issued the address. There are four sources: the processor, the drum channel, the tape channel and interrupt control. When a processor reference misses, or hits a locked frame, the address is captured for software and a one-cycle interrupt request is raised. When a channel reference misses or hits a locked frame, the result is a fault. Instruction-pair fetches run speculatively on the frame held in a last-page register, and the comparison then confirms or rejects that frame. Software reads and writes the page registers through a small register port. Software also reads the use bits in 16-bit words, and each read clears the word it returns.

Requests enter on a valid/ready handshake. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. A response stays valid, with every field stable, until `rsp_ready` is seen high. A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and its response appears after that edge.

Top module: `assoc_page_map`

## Requirements
- R1: After reset, frame i holds block i with lockout 0, every use bit is 0, the last-page register is 0, and no response is valid. A register read of page index i returns the block number in bits [10:0] and the lockout bit in bit 11.
- R2: The address is {paged-select bit 20, block [19:9], offset [8:0]}, and select 0 means paged. A paged address that matches exactly one unlocked frame gives kind HIT (0) with grant. The physical address is {frame index, offset} (14 bits).
- R3: A paged processor (source 0) or interrupt-control (source 3) address that matches no frame gives kind MISS (1) and no grant.
- R4: A processor address that matches a frame with lockout 1 gives kind LOCKED (2) and no grant. Drum (1), tape (2) and interrupt control (3) are granted a HIT on a locked frame.
- R5: A drum or tape address that matches no frame gives kind FAULT (3) and no grant.
- R6: If more than one page register matches, the result is kind FAULT (3) with no grant, for every source.
- R7: An address with bit 20 set gives kind OUTSIDE (4). It has no grant and no interrupt, and it sets no use bit.
- R8: A MISS or LOCKED result stores the full request address in capture register index 32. It also pulses `irq` for exactly the cycle in which that response first becomes valid.
- R9: For a processor pair fetch that hits, the true frame is compared with the last-page register (`spec_frame`). If they differ, the response carries `rsp_wrong_page`, has no grant, and the last-page register takes the true frame. If they agree, the response is granted. Only processor pair fetches load the last-page register.
- R10: Every granted access sets its frame's use bit. Register indices 33 and 34 read use bits 15..0 and 31..16. A read strobe on one of these indices clears that word, but a set in the same cycle wins.
- R11: A response held with `rsp_ready` low keeps all its fields stable, and `req_ready` stays low until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 21 | Demanded address |
| req_src | input | 2 | 0 processor, 1 drum, 2 tape, 3 interrupt control |
| req_pair | input | 1 | Instruction-pair fetch (processor only) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_kind | output | 3 | 0 HIT, 1 MISS, 2 LOCKED, 3 FAULT, 4 OUTSIDE |
| rsp_grant | output | 1 | Bank access / read-out allowed |
| rsp_wrong_page | output | 1 | Speculative pair frame was wrong |
| rsp_paddr | output | 14 | Physical address on HIT, else 0 |
| spec_frame | output | 5 | Last-page register, used to start pair fetches |
| irq | output | 1 | Interrupt request pulse |
| reg_addr | input | 6 | Register index: 0..31 pages, 32 capture, 33..34 use words |
| reg_wr | input | 1 | Write strobe (page registers only) |
| reg_wdata | input | 12 | {lockout, block} write data |
| reg_rd | input | 1 | Read strobe; clears an addressed use word |
| reg_rdata | output | 21 | Read data for reg_addr |

## Verification
If the page registers are corrupted, wrong translations or spurious FAULTs show up on the very next response that touches the damaged frame. A bad last-page register shows up at once on `spec_frame`, and on the next pair fetch as a wrong-page flag that should not be there. Use bits that are set wrongly or not cleared stay hidden until the next use-word read. Corruption of the capture register is visible only through its register index. Such faults therefore come out one response or one register read later, while faults in the kind or grant decode come out in the cycle right after acceptance.

// File: rtl/apm_pkg.sv
package apm_pkg;
  typedef enum logic [2:0] {
    K_HIT     = 3'd0,
    K_MISS    = 3'd1,
    K_LOCKED  = 3'd2,
    K_FAULT   = 3'd3,
    K_OUTSIDE = 3'd4
  } kind_e;

  localparam logic [1:0] SRC_CPU  = 2'd0;
  localparam logic [1:0] SRC_DRUM = 2'd1;
  localparam logic [1:0] SRC_TAPE = 2'd2;
  localparam logic [1:0] SRC_INTC = 2'd3;
endpackage

// File: rtl/apm_frame_cam.sv
module apm_frame_cam #(
  parameter int NF = 32,
  parameter int BW = 11,
  localparam int FW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_idx,
  input  logic [BW-1:0] wr_blk,
  input  logic          wr_lock,
  input  logic [BW-1:0] lk_blk,
  output logic          hit_any,
  output logic          hit_multi,
  output logic [FW-1:0] hit_idx,
  output logic          hit_lock,
  input  logic [FW-1:0] rd_idx,
  output logic [BW-1:0] rd_blk,
  output logic          rd_lock
);
  logic [BW-1:0] blk_q  [NF];
  logic [NF-1:0] lock_q;
  logic [NF-1:0] match;

  for (genvar g = 0; g < NF; g++) begin : g_frame
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        blk_q[g]  <= BW'(g);
        lock_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == FW'(g)) begin
        blk_q[g]  <= wr_blk;
        lock_q[g] <= wr_lock;
      end
    end
    assign match[g] = (blk_q[g] == lk_blk);
  end

  always_comb begin
    logic [$clog2(NF+1)-1:0] cnt;
    cnt      = '0;
    hit_idx  = '0;
    hit_lock = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (match[i]) begin
        cnt      = cnt + 1'b1;
        hit_idx  = hit_idx | FW'(i);
        hit_lock = hit_lock | lock_q[i];
      end
    end
    hit_any   = (cnt != '0);
    hit_multi = (cnt > 1);
  end

  assign rd_blk  = blk_q[rd_idx];
  assign rd_lock = lock_q[rd_idx];
endmodule

// File: rtl/apm_use_bits.sv
module apm_use_bits #(
  parameter int NF = 32,
  parameter int UW = 16,
  localparam int FW = $clog2(NF),
  localparam int NW = NF / UW,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [FW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [WW-1:0] word_idx,
  output logic [UW-1:0] word_data
);
  logic [NF-1:0] use_q;

  for (genvar g = 0; g < NF; g++) begin : g_bit
    localparam int WORD = g / UW;
    always_ff @(posedge clk) begin
      if (!rst_n)
        use_q[g] <= 1'b0;
      else if (set_en && set_idx == FW'(g))
        use_q[g] <= 1'b1;
      else if (clr_en && word_idx == WW'(WORD))
        use_q[g] <= 1'b0;
    end
  end

  assign word_data = use_q[word_idx*UW +: UW];
endmodule

// File: rtl/assoc_page_map.sv
module assoc_page_map
  import apm_pkg::*;
#(
  parameter int NF    = 32,
  parameter int BLK_W = 11,
  parameter int OFS_W = 9,
  parameter int USE_W = 16,
  localparam int FW     = $clog2(NF),
  localparam int ADDR_W = 1 + BLK_W + OFS_W,
  localparam int PA_W   = FW + OFS_W,
  localparam int NUSE   = NF / USE_W,
  localparam int RA_W   = $clog2(NF + 1 + NUSE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_src,
  input  logic              req_pair,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_kind,
  output logic              rsp_grant,
  output logic              rsp_wrong_page,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FW-1:0]     spec_frame,
  output logic              irq,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [BLK_W:0]    reg_wdata,
  input  logic              reg_rd,
  output logic [ADDR_W-1:0] reg_rdata
);
  localparam int CAP_IDX = NF;
  localparam int USE_IDX = NF + 1;
  localparam int UWW     = (NUSE > 1) ? $clog2(NUSE) : 1;

  logic [BLK_W-1:0] lk_blk;
  logic             paged;
  logic             hit_any, hit_multi, hit_lock;
  logic [FW-1:0]    hit_idx;
  logic [BLK_W-1:0] rd_blk;
  logic             rd_lock;
  logic [USE_W-1:0] use_word;
  logic             accept;
  logic             is_chan, is_pair;
  kind_e            kind_d;
  logic             grant_d, wp_d, cap_d;
  logic [FW-1:0]    last_q;
  logic [ADDR_W-1:0] cap_q;
  logic             pg_sel, use_sel;
  logic [UWW-1:0]   use_widx;

  assign lk_blk  = req_addr[OFS_W +: BLK_W];
  assign paged   = !req_addr[ADDR_W-1];
  assign is_chan = (req_src == SRC_DRUM) || (req_src == SRC_TAPE);
  assign is_pair = req_pair && (req_src == SRC_CPU);
  assign accept  = req_valid && req_ready;
  assign req_ready = !rsp_valid || rsp_ready;

  assign pg_sel   = (reg_addr < RA_W'(NF));
  assign use_sel  = (reg_addr >= RA_W'(USE_IDX)) && (reg_addr < RA_W'(USE_IDX + NUSE));
  assign use_widx = UWW'(reg_addr - RA_W'(USE_IDX));

  apm_frame_cam #(.NF(NF), .BW(BLK_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && pg_sel), .wr_idx(reg_addr[FW-1:0]),
    .wr_blk(reg_wdata[BLK_W-1:0]), .wr_lock(reg_wdata[BLK_W]),
    .lk_blk(lk_blk),
    .hit_any(hit_any), .hit_multi(hit_multi), .hit_idx(hit_idx), .hit_lock(hit_lock),
    .rd_idx(reg_addr[FW-1:0]), .rd_blk(rd_blk), .rd_lock(rd_lock)
  );

  apm_use_bits #(.NF(NF), .UW(USE_W)) u_use (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept && grant_d), .set_idx(hit_idx),
    .clr_en(reg_rd && use_sel), .word_idx(use_widx),
    .word_data(use_word)
  );

  always_comb begin
    kind_d  = K_HIT;
    grant_d = 1'b0;
    wp_d    = 1'b0;
    cap_d   = 1'b0;
    if (!paged) begin
      kind_d = K_OUTSIDE;
    end else if (hit_multi) begin
      kind_d = K_FAULT;
    end else if (!hit_any) begin
      kind_d = is_chan ? K_FAULT : K_MISS;
      cap_d  = !is_chan;
    end else if (hit_lock && req_src == SRC_CPU) begin
      kind_d = K_LOCKED;
      cap_d  = 1'b1;
    end else if (is_pair && hit_idx != last_q) begin
      wp_d   = 1'b1;
    end else begin
      grant_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_kind       <= K_HIT;
      rsp_grant      <= 1'b0;
      rsp_wrong_page <= 1'b0;
      rsp_paddr      <= '0;
      irq            <= 1'b0;
      last_q         <= '0;
      cap_q          <= '0;
    end else begin
      irq <= accept && cap_d;
      if (accept) begin
        rsp_valid      <= 1'b1;
        rsp_kind       <= kind_d;
        rsp_grant      <= grant_d;
        rsp_wrong_page <= wp_d;
        rsp_paddr      <= (kind_d == K_HIT) ? {hit_idx, req_addr[OFS_W-1:0]} : '0;
        if (cap_d) cap_q <= req_addr;
        if (is_pair && kind_d == K_HIT) last_q <= hit_idx;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign spec_frame = last_q;

  always_comb begin
    reg_rdata = '0;
    if (pg_sel)
      reg_rdata = ADDR_W'({rd_lock, rd_blk});
    else if (reg_addr == RA_W'(CAP_IDX))
      reg_rdata = cap_q;
    else if (use_sel)
      reg_rdata = ADDR_W'(use_word);
  end
endmodule

// File: rtl/apm_checker.sv
module apm_checker #(
  parameter int PA_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2:0]      rsp_kind,
  input logic            rsp_grant,
  input logic            rsp_wrong_page,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            irq
);
  AST_GRANT_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_grant |-> rsp_kind == 3'd0); // R2
  AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rsp_valid && (rsp_kind == 3'd1 || rsp_kind == 3'd2)); // R8
  AST_WRONG_PAGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wrong_page |-> !rsp_grant && rsp_kind == 3'd0); // R9
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 3'd4 |-> !rsp_grant && !irq); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_grant)
      && $stable(rsp_paddr) && $stable(rsp_wrong_page)); // R11
  AST_NO_ACCEPT_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R11
endmodule

bind assoc_page_map apm_checker #(.PA_W(PA_W)) u_apm_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_grant(rsp_grant),
  .rsp_wrong_page(rsp_wrong_page), .rsp_paddr(rsp_paddr), .irq(irq)
);

// File: tb/tb_assoc_page_map.sv
module tb_assoc_page_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_pair = 0, rsp_ready = 1;
  logic [20:0] req_addr = '0;
  logic [1:0]  req_src = '0;
  logic        req_ready, rsp_valid, rsp_grant, rsp_wrong_page, irq;
  logic [2:0]  rsp_kind;
  logic [13:0] rsp_paddr;
  logic [4:0]  spec_frame;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_wdata = '0;
  logic [20:0] reg_rdata;

  assoc_page_map dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_src(req_src), .req_pair(req_pair),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_grant(rsp_grant), .rsp_wrong_page(rsp_wrong_page), .rsp_paddr(rsp_paddr),
    .spec_frame(spec_frame), .irq(irq), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] mk(input int blk, input int ofs);
    return {1'b0, 11'(blk), 9'(ofs)};
  endfunction

  typedef struct packed {
    logic [1:0]  src;
    logic        pair;
    logic [20:0] addr;
    logic [2:0]  kind;
    logic        grant;
    logic        wp;
    logic [13:0] paddr;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{2'd0, 1'b0, mk(100, 'h012), 3'd0, 1'b1, 1'b0, {5'd5, 9'h012}},   // R2
    '{2'd0, 1'b0, mk(5, 'h001),   3'd1, 1'b0, 1'b0, 14'd0},             // R3
    '{2'd1, 1'b0, mk(5, 'h001),   3'd3, 1'b0, 1'b0, 14'd0},             // R5
    '{2'd0, 1'b0, mk(7, 'h0a0),   3'd2, 1'b0, 1'b0, 14'd0},             // R4
    '{2'd1, 1'b0, mk(7, 'h0a1),   3'd0, 1'b1, 1'b0, {5'd7, 9'h0a1}},    // R4
    '{2'd2, 1'b0, mk(7, 'h1ff),   3'd0, 1'b1, 1'b0, {5'd7, 9'h1ff}},    // R4
    '{2'd3, 1'b0, mk(7, 'h000),   3'd0, 1'b1, 1'b0, {5'd7, 9'h000}},    // R4
    '{2'd2, 1'b0, mk(200, 'h003), 3'd3, 1'b0, 1'b0, 14'd0},             // R5
    '{2'd0, 1'b0, mk(3, 'h004),   3'd3, 1'b0, 1'b0, 14'd0},             // R6
    '{2'd0, 1'b0, 21'h100005,     3'd4, 1'b0, 1'b0, 14'd0},             // R7
    '{2'd0, 1'b1, mk(0, 'h010),   3'd0, 1'b1, 1'b0, {5'd0, 9'h010}},    // R9
    '{2'd0, 1'b1, mk(2, 'h020),   3'd0, 1'b0, 1'b1, {5'd2, 9'h020}},    // R9
    '{2'd0, 1'b1, mk(2, 'h022),   3'd0, 1'b1, 1'b0, {5'd2, 9'h022}},    // R9
    '{2'd1, 1'b1, mk(0, 'h030),   3'd0, 1'b1, 1'b0, {5'd0, 9'h030}},    // R9
    '{2'd0, 1'b1, mk(2, 'h024),   3'd0, 1'b1, 1'b0, {5'd2, 9'h024}},    // R9
    '{2'd3, 1'b0, mk(300, 'h055), 3'd1, 1'b0, 1'b0, 14'd0}              // R3
  };

  task automatic wr_reg(input int idx, input logic [11:0] d);
    @(negedge clk);
    reg_addr = 6'(idx); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input int idx, input logic strobe, output logic [20:0] d);
    @(negedge clk);
    reg_addr = 6'(idx);
    #1 d = reg_rdata;
    reg_rd = strobe;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic send(input vec_t v);
    @(negedge clk);
    req_valid = 1; req_src = v.src; req_pair = v.pair; req_addr = v.addr;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [20:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 spec_frame", 32'(spec_frame), 0);
    rd_reg(5, 0, d);  chk("R1 page5", 32'(d), 5);
    rd_reg(31, 0, d); chk("R1 page31", 32'(d), 31);
    rd_reg(33, 1, d); chk("R1 use lo", 32'(d), 0);
    rd_reg(34, 1, d); chk("R1 use hi", 32'(d), 0);

    wr_reg(5, {1'b0, 11'd100});
    wr_reg(7, {1'b1, 11'd7});
    wr_reg(9, {1'b0, 11'd3});
    rd_reg(7, 0, d); chk("R1 page7 lock field", 32'(d), 32'h807);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i]);
      chk($sformatf("R2 vec%0d valid", i), 32'(rsp_valid), 1);
      chk($sformatf("R2-kind vec%0d", i), 32'(rsp_kind), 32'(VEC[i].kind));
      chk($sformatf("R2 grant vec%0d", i), 32'(rsp_grant), 32'(VEC[i].grant));
      chk($sformatf("R9 wrong_page vec%0d", i), 32'(rsp_wrong_page), 32'(VEC[i].wp));
      chk($sformatf("R2 paddr vec%0d", i), 32'(rsp_paddr), 32'(VEC[i].paddr));
      chk($sformatf("R8 irq vec%0d", i), 32'(irq),
          32'(VEC[i].kind == 3'd1 || VEC[i].kind == 3'd2));
      if (i == 11) chk("R9 spec after wrong page", 32'(spec_frame), 2);
      if (i == 13) chk("R9 channel pair keeps spec", 32'(spec_frame), 2);
    end
    @(negedge clk);
    chk("R8 irq one cycle", 32'(irq), 0);
    rd_reg(32, 0, d); chk("R8 capture", 32'(d), 32'(mk(300, 'h055)));

    // R10 use bits: frames 0,2,5,7 granted
    rd_reg(33, 1, d); chk("R10 use lo", 32'(d), 32'h00a5);
    rd_reg(34, 1, d); chk("R10 use hi", 32'(d), 0);
    rd_reg(33, 1, d); chk("R10 use lo cleared", 32'(d), 0);

    // R10 set beats clear in same cycle
    @(negedge clk);
    reg_addr = 6'd33; reg_rd = 1;
    req_valid = 1; req_src = 2'd0; req_pair = 0; req_addr = mk(100, 1);
    @(negedge clk);
    reg_rd = 0; req_valid = 0;
    rd_reg(33, 1, d); chk("R10 set wins over clear", 32'(d), 32'h0020);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_src = 2'd1; req_pair = 0; req_addr = mk(1, 'h0aa);
    @(negedge clk);
    req_addr = mk(4, 'h0bb);
    chk("R11 ready low while held", 32'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 held kind", 32'(rsp_kind), 0);
    chk("R11 held paddr", 32'(rsp_paddr), 32'({5'd1, 9'h0aa}));
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R11 next request taken", 32'(rsp_paddr), 32'({5'd4, 9'h0bb}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule